// File: doc/BRIEF.md
# Bridge Prefetchable Window Decoder

This block sits in one port of a PCI-to-PCI bridge. It holds the prefetchable memory window of the port, with 64-bit bounds and 1 MB granularity, and the 32-bit non-prefetchable memory window. It decides for every memory request whether the bridge claims it. Software programs the windows through a small configuration read/write port that decodes the dwords at offsets 20h, 24h, 28h and 2Ch.

A request seen on the primary side is forwarded downstream when its address falls inside either window. A request seen on the secondary side is forwarded upstream only when its address falls outside both windows. A window whose effective base lies above its effective limit is empty. Both windows come out of reset empty, so nothing is claimed downstream and everything is passed upstream until software opens a window.

Top module: `pfwin_decoder`

## Requirements
- R1: In dword 24h, bits [3:0] and bits [19:16] always read 1h, which marks 64-bit prefetchable support. Writes to these nibbles have no effect.
- R2: After reset, dword 24h reads 0001FFF1h, dword 20h reads 0000FFF0h, and dwords 28h and 2Ch read 0. The write-only fields reset to base FFFh and limit 000h.
- R3: A write to 20h or 24h stores bits [15:4] as the base field and bits [31:20] as the limit field. A write to 28h or 2Ch stores all 32 bits. A read returns the register value from before any write in the same cycle. `cfg_rdata` carries that value from the cycle after the read strobe and holds it until the next read. A read of any other offset returns 0.
- R4: The effective prefetchable base is {28h, base field, 20 zero bits}. The effective limit is {2Ch, limit field, 20 one bits}. A primary request whose address is at or above the base and at or below the limit (unsigned 64-bit compare) raises `dn_fwd`.
- R5: If the effective prefetchable base is greater than its limit, no address is inside that window. This is true for both the downstream test and the upstream test.
- R6: The non-prefetchable window spans {32 zero bits, 20h base field, 20 zero bits} to {32 zero bits, 20h limit field, 20 one bits}. A primary request inside it also raises `dn_fwd`. It is empty when its base exceeds its limit.
- R7: A secondary request raises `up_fwd` exactly when its address is outside both windows.
- R8: `dn_fwd` is low whenever `pri_req` is low, and `up_fwd` is low whenever `sec_req` is low. Both flags follow their request in the same cycle, using the registers as they stand in that cycle.
- R9: Bits [3:0] and [19:16] of dword 20h always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset (bits [1:0] ignored) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered read data |
| pri_req | input | 1 | Memory request present on the primary side |
| pri_addr | input | ADDR_W | Primary request address |
| sec_req | input | 1 | Memory request present on the secondary side |
| sec_addr | input | ADDR_W | Secondary request address |
| dn_fwd | output | 1 | Forward primary request downstream |
| up_fwd | output | 1 | Forward secondary request upstream |

## Verification
The forwarding flags are combinational, so they are due in the same cycle as the request. They reflect a configuration write from the first cycle after the write edge. Read data is due one clock after the read strobe. The bench therefore drives inputs on the falling edge and samples the flags a moment later. It samples `cfg_rdata` on the falling edge that follows the rising edge which took the strobe. A behavioural model updated on the same rising edges is compared with both flags and the read data in every cycle, and directed checks pin the window edges one address apart.

// File: rtl/pfwin_pkg.sv
package pfwin_pkg;
   localparam logic [7:0] OFF_NPWIN   = 8'h20;
   localparam logic [7:0] OFF_PFWIN   = 8'h24;
   localparam logic [7:0] OFF_PFBASEU = 8'h28;
   localparam logic [7:0] OFF_PFLIMU  = 8'h2C;
   localparam int unsigned NWIN       = 2;
   localparam int unsigned WIN_PF     = 0;
   localparam int unsigned WIN_NP     = 1;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_NP, SEL_PF, SEL_BU, SEL_LU
   } cfg_sel_e;
endpackage

// File: rtl/pfwin_cfg_regs.sv
module pfwin_cfg_regs
   import pfwin_pkg::*;
#(
   parameter int unsigned CFG_AW    = 8,
   parameter int unsigned FLD_W     = 12,
   parameter logic [3:0]  CAP_CODE  = 4'h1,
   parameter logic [FLD_W-1:0] BASE_RST  = '1,
   parameter logic [FLD_W-1:0] LIMIT_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic [FLD_W-1:0]  np_base,
   output logic [FLD_W-1:0]  np_limit,
   output logic [FLD_W-1:0]  pf_base,
   output logic [FLD_W-1:0]  pf_limit,
   output logic [31:0]       pf_base_up,
   output logic [31:0]       pf_limit_up
);
   localparam logic [CFG_AW-1:0] A_NP = CFG_AW'(OFF_NPWIN);
   localparam logic [CFG_AW-1:0] A_PF = CFG_AW'(OFF_PFWIN);
   localparam logic [CFG_AW-1:0] A_BU = CFG_AW'(OFF_PFBASEU);
   localparam logic [CFG_AW-1:0] A_LU = CFG_AW'(OFF_PFLIMU);

   cfg_sel_e   sel;
   logic [31:0] rd_mux;
   logic        unused_bits;

   assign unused_bits = ^{cfg_addr[1:0], cfg_wdata[19:16], cfg_wdata[3:0]};

   always_comb begin
      if      (cfg_addr[CFG_AW-1:2] == A_NP[CFG_AW-1:2]) sel = SEL_NP;
      else if (cfg_addr[CFG_AW-1:2] == A_PF[CFG_AW-1:2]) sel = SEL_PF;
      else if (cfg_addr[CFG_AW-1:2] == A_BU[CFG_AW-1:2]) sel = SEL_BU;
      else if (cfg_addr[CFG_AW-1:2] == A_LU[CFG_AW-1:2]) sel = SEL_LU;
      else                                                sel = SEL_NONE;
   end

   always_comb begin
      unique case (sel)
         SEL_NP:  rd_mux = {np_limit, 4'h0, np_base, 4'h0};
         SEL_PF:  rd_mux = {pf_limit, CAP_CODE, pf_base, CAP_CODE};
         SEL_BU:  rd_mux = pf_base_up;
         SEL_LU:  rd_mux = pf_limit_up;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         np_base     <= BASE_RST;
         np_limit    <= LIMIT_RST;
         pf_base     <= BASE_RST;
         pf_limit    <= LIMIT_RST;
         pf_base_up  <= '0;
         pf_limit_up <= '0;
         cfg_rdata   <= '0;
      end else begin
         if (cfg_rd) cfg_rdata <= rd_mux;
         if (cfg_wr) begin
            unique case (sel)
               SEL_NP: begin
                  np_base  <= cfg_wdata[15:4];
                  np_limit <= cfg_wdata[31:20];
               end
               SEL_PF: begin
                  pf_base  <= cfg_wdata[15:4];
                  pf_limit <= cfg_wdata[31:20];
               end
               SEL_BU:  pf_base_up  <= cfg_wdata;
               SEL_LU:  pf_limit_up <= cfg_wdata;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pfwin_window.sv
module pfwin_window #(
   parameter int unsigned ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   output logic              hit_a,
   output logic              hit_b
);
   logic open_win;

   assign open_win = (lo <= hi);
   assign hit_a    = open_win && (addr_a >= lo) && (addr_a <= hi);
   assign hit_b    = open_win && (addr_b >= lo) && (addr_b <= hi);
endmodule

// File: rtl/pfwin_decoder.sv
module pfwin_decoder
   import pfwin_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned GRAN_W    = 20,
   parameter int unsigned CFG_AW    = 8,
   parameter logic [3:0]  CAP_CODE  = 4'h1,
   parameter logic [11:0] BASE_RST  = 12'hFFF,
   parameter logic [11:0] LIMIT_RST = 12'h000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              pri_req,
   input  logic [ADDR_W-1:0] pri_addr,
   input  logic              sec_req,
   input  logic [ADDR_W-1:0] sec_addr,
   output logic              dn_fwd,
   output logic              up_fwd
);
   localparam int unsigned FLD_W = 32 - GRAN_W;
   localparam int unsigned UP_W  = ADDR_W - 32;

   if (ADDR_W != 64) begin : g_bad_aw
      $error("pfwin_decoder: ADDR_W must be 64");
   end
   if (GRAN_W != 20) begin : g_bad_gran
      $error("pfwin_decoder: GRAN_W must be 20 to match the field layout");
   end
   if (CFG_AW < 6) begin : g_bad_cfg
      $error("pfwin_decoder: CFG_AW must reach offset 2Ch");
   end

   logic [FLD_W-1:0]  np_base, np_limit, pf_base, pf_limit;
   logic [31:0]       pf_base_up, pf_limit_up;
   logic [ADDR_W-1:0] win_lo [NWIN];
   logic [ADDR_W-1:0] win_hi [NWIN];
   logic [NWIN-1:0]   hit_pri, hit_sec;

   pfwin_cfg_regs #(
      .CFG_AW    (CFG_AW),
      .FLD_W     (FLD_W),
      .CAP_CODE  (CAP_CODE),
      .BASE_RST  (BASE_RST),
      .LIMIT_RST (LIMIT_RST)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_rd      (cfg_rd),
      .cfg_addr    (cfg_addr),
      .cfg_wdata   (cfg_wdata),
      .cfg_rdata   (cfg_rdata),
      .np_base     (np_base),
      .np_limit    (np_limit),
      .pf_base     (pf_base),
      .pf_limit    (pf_limit),
      .pf_base_up  (pf_base_up),
      .pf_limit_up (pf_limit_up)
   );

   assign win_lo[WIN_PF] = {pf_base_up[UP_W-1:0],  pf_base,  {GRAN_W{1'b0}}};
   assign win_hi[WIN_PF] = {pf_limit_up[UP_W-1:0], pf_limit, {GRAN_W{1'b1}}};
   assign win_lo[WIN_NP] = {{UP_W{1'b0}}, np_base,  {GRAN_W{1'b0}}};
   assign win_hi[WIN_NP] = {{UP_W{1'b0}}, np_limit, {GRAN_W{1'b1}}};

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      pfwin_window #(.ADDR_W(ADDR_W)) u_win (
         .lo     (win_lo[w]),
         .hi     (win_hi[w]),
         .addr_a (pri_addr),
         .addr_b (sec_addr),
         .hit_a  (hit_pri[w]),
         .hit_b  (hit_sec[w])
      );
   end

   assign dn_fwd = pri_req &&  (|hit_pri);
   assign up_fwd = sec_req && !(|hit_sec);
endmodule

// File: rtl/pfwin_decoder_chk.sv
module pfwin_decoder_chk #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned CFG_AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_rd,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [31:0]       cfg_rdata,
   input logic              pri_req,
   input logic [ADDR_W-1:0] pri_addr,
   input logic              sec_req,
   input logic [ADDR_W-1:0] sec_addr,
   input logic              dn_fwd,
   input logic              up_fwd
);
   localparam logic [CFG_AW-1:0] A_NP = CFG_AW'(8'h20);
   localparam logic [CFG_AW-1:0] A_PF = CFG_AW'(8'h24);

   a_r1_cap_nibbles: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_addr[CFG_AW-1:2] == A_PF[CFG_AW-1:2])
      |=> (cfg_rdata[3:0] == 4'h1 && cfg_rdata[19:16] == 4'h1));

   a_r9_np_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_addr[CFG_AW-1:2] == A_NP[CFG_AW-1:2])
      |=> (cfg_rdata[3:0] == 4'h0 && cfg_rdata[19:16] == 4'h0));

   a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd |=> $stable(cfg_rdata));

   a_r8_dn_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      dn_fwd |-> pri_req);

   a_r8_up_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      up_fwd |-> sec_req);

   a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_req && sec_req && pri_addr == sec_addr) |-> (dn_fwd != up_fwd));
endmodule

bind pfwin_decoder pfwin_decoder_chk #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_rd    (cfg_rd),
   .cfg_addr  (cfg_addr),
   .cfg_rdata (cfg_rdata),
   .pri_req   (pri_req),
   .pri_addr  (pri_addr),
   .sec_req   (sec_req),
   .sec_addr  (sec_addr),
   .dn_fwd    (dn_fwd),
   .up_fwd    (up_fwd)
);

// File: tb/pfwin_decoder_tb.sv
module pfwin_decoder_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_wr = 0, cfg_rd = 0;
   logic [7:0]  cfg_addr = 0;
   logic [31:0] cfg_wdata = 0;
   logic [31:0] cfg_rdata;
   logic        pri_req = 0, sec_req = 0;
   logic [63:0] pri_addr = 0, sec_addr = 0;
   logic        dn_fwd, up_fwd;

   int checks = 0;
   int errors = 0;
   bit running = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfwin_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pri_req(pri_req), .pri_addr(pri_addr), .sec_req(sec_req),
      .sec_addr(sec_addr), .dn_fwd(dn_fwd), .up_fwd(up_fwd)
   );

   // reference model state
   logic [11:0] m_npb, m_npl, m_pfb, m_pfl;
   logic [31:0] m_bu, m_lu, m_rd;

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a & 8'hFC)
         8'h20:   return {m_npl, 4'h0, m_npb, 4'h0};
         8'h24:   return {m_pfl, 4'h1, m_pfb, 4'h1};
         8'h28:   return m_bu;
         8'h2C:   return m_lu;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit m_inside(input logic [63:0] a);
      logic [63:0] plo, phi, nlo, nhi;
      bit inp, inn;
      plo = (64'(m_bu) << 32) + (64'(m_pfb) << 20);
      phi = (64'(m_lu) << 32) + (64'(m_pfl) << 20) + 64'hFFFFF;
      nlo = 64'(m_npb) << 20;
      nhi = (64'(m_npl) << 20) + 64'hFFFFF;
      inp = (plo <= phi) && (a >= plo) && (a <= phi);
      inn = (nlo <= nhi) && (a >= nlo) && (a <= nhi);
      return inp || inn;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_npb = 12'hFFF; m_npl = 12'h000;
         m_pfb = 12'hFFF; m_pfl = 12'h000;
         m_bu = 0; m_lu = 0; m_rd = 0;
      end else begin
         if (cfg_rd) m_rd = m_read(cfg_addr);
         if (cfg_wr) begin
            case (cfg_addr & 8'hFC)
               8'h20: begin m_npb = cfg_wdata[15:4]; m_npl = cfg_wdata[31:20]; end
               8'h24: begin m_pfb = cfg_wdata[15:4]; m_pfl = cfg_wdata[31:20]; end
               8'h28: m_bu = cfg_wdata;
               8'h2C: m_lu = cfg_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison with the model
   always @(negedge clk) begin
      #2;
      if (running && rst_n) begin
         chk("R4 R6 R8 model dn_fwd", 64'(dn_fwd), 64'(pri_req && m_inside(pri_addr)));
         chk("R5 R7 R8 model up_fwd", 64'(up_fwd), 64'(sec_req && !m_inside(sec_addr)));
         chk("R3 model rdata", 64'(cfg_rdata), 64'(m_rd));
      end
   end

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 0;
   endtask

   task automatic cfg_read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      cfg_rd = 1; cfg_addr = a;
      @(negedge clk);
      cfg_rd = 0;
      #1;
      chk(req, 64'(cfg_rdata), 64'(exp));
   endtask

   task automatic probe(input string req, input logic [63:0] a,
                        input bit exp_dn, input bit exp_up);
      @(negedge clk);
      pri_req = 1; sec_req = 1; pri_addr = a; sec_addr = a;
      #1;
      chk({req, " dn"}, 64'(dn_fwd), 64'(exp_dn));
      chk({req, " up"}, 64'(up_fwd), 64'(exp_up));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      running = 1;
      // R2 reset values, R1 and R9 fixed nibbles
      cfg_read_chk("R2 R1 reset 24h", 8'h24, 32'h0001FFF1);
      cfg_read_chk("R2 R9 reset 20h", 8'h20, 32'h0000FFF0);
      cfg_read_chk("R2 reset 28h", 8'h28, 32'h0);
      cfg_read_chk("R2 reset 2Ch", 8'h2C, 32'h0);
      // R5 reset windows empty: nothing down, everything up
      probe("R5 reset empty", 64'h0, 0, 1);
      probe("R5 reset empty hi", 64'hFFF0_0000, 0, 1);
      // R8 no request no flag
      @(negedge clk); pri_req = 0; sec_req = 0; #1;
      chk("R8 idle dn", 64'(dn_fwd), 64'h0);
      chk("R8 idle up", 64'(up_fwd), 64'h0);
      // R1 writes to capability nibbles ignored
      cfg_write(8'h24, 32'h000F_000E);
      cfg_read_chk("R1 cap ignored", 8'h24, 32'h0001_0001);
      // R3 unmapped reads zero
      cfg_read_chk("R3 unmapped", 8'h30, 32'h0);
      // program prefetchable window 1_2340_0000 .. 1_456F_FFFF
      cfg_write(8'h28, 32'h1);
      cfg_write(8'h2C, 32'h1);
      cfg_write(8'h24, {12'h456, 4'h0, 12'h234, 4'h0});
      cfg_read_chk("R3 R1 readback 24h", 8'h24, 32'h4561_2341);
      cfg_read_chk("R3 readback 28h", 8'h28, 32'h1);
      probe("R4 base edge", 64'h1_2340_0000, 1, 0);
      probe("R4 below base", 64'h1_233F_FFFF, 0, 1);
      probe("R4 limit edge", 64'h1_456F_FFFF, 1, 0);
      probe("R4 above limit", 64'h1_4570_0000, 0, 1);
      probe("R4 upper bits differ", 64'h0_2340_0000, 0, 1);
      // non-prefetchable window 1000_0000 .. 1FFF_FFFF
      cfg_write(8'h20, {12'h1FF, 4'hF, 12'h100, 4'hF});
      cfg_read_chk("R9 R3 readback 20h", 8'h20, 32'h1FF0_1000);
      probe("R6 np inside", 64'h1000_0000, 1, 0);
      probe("R6 np top", 64'h1FFF_FFFF, 1, 0);
      probe("R7 outside both", 64'h2000_0000, 0, 1);
      probe("R6 np 32-bit only", 64'h1_1000_0000, 0, 1);
      // R5 inverted prefetchable window
      cfg_write(8'h24, {12'h400, 4'h0, 12'h500, 4'h0});
      probe("R5 inverted", 64'h1_4800_0000, 0, 1);
      probe("R5 inverted np still", 64'h1800_0000, 1, 0);
      // R3 same-cycle read and write returns old value
      @(negedge clk);
      cfg_rd = 1; cfg_wr = 1; cfg_addr = 8'h2C; cfg_wdata = 32'hABCD_0123;
      @(negedge clk);
      cfg_rd = 0; cfg_wr = 0; #1;
      chk("R3 read before write", 64'(cfg_rdata), 64'h1);
      cfg_read_chk("R3 write landed", 8'h2C, 32'hABCD_0123);
      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         cfg_wr = ($urandom_range(0, 7) == 0);
         cfg_rd = ($urandom_range(0, 3) == 0);
         cfg_addr = 8'h1C + 8'(4 * $urandom_range(0, 5)) + 8'($urandom_range(0, 3));
         cfg_wdata = $urandom & 32'hFF0F_FF0F;
         if ($urandom_range(0, 1) == 0) cfg_wdata[31:20] = cfg_wdata[15:4] + 12'($urandom_range(0, 3));
         if (cfg_addr[7:2] == 6'h0A || cfg_addr[7:2] == 6'h0B) cfg_wdata = 32'($urandom_range(0, 2));
         pri_req = $urandom_range(0, 1);
         sec_req = $urandom_range(0, 1);
         pri_addr = {32'($urandom_range(0, 2)), $urandom};
         sec_addr = ($urandom_range(0, 1) == 0) ? pri_addr : {32'($urandom_range(0, 2)), $urandom};
      end
      @(negedge clk);
      cfg_wr = 0; cfg_rd = 0; pri_req = 0; sec_req = 0;
      @(negedge clk);
      #3;
      running = 0;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule